// File: doc/BRIEF.md
# Serial Control-Word Loader for a Frequency Synthesiser

This block takes the synthesiser's divider settings over a three-wire serial port (a data line, a bit clock and a frame enable) and holds them in latches that the divider logic reads. Every wire is asynchronous to the system clock. Each wire passes through a synchroniser, and the block then finds the edges. While the enable line is high, a data bit is taken on each falling edge of the bit clock. The falling edge of the enable line moves the collected fields into the output latches. In the same cycle a one-cycle strobe goes out so that the reference and main divider chains can resynchronise to each other.

A full frame holds 30 bits and sets every field. A short frame of 19 bits updates the swallow count, the main count and the two band outputs, and the reference divisor is left alone. Bits are placed by their position counted from the first bit of the frame. Clock edges after the thirtieth are dropped. A reference divisor below 3 is refused.

Top module: `ser_word_loader`

## Requirements
- R1: After reset, word_a_o, word_m_o, word_r_o, band_o and xfer_o are all zero.
- R2: Frame bit k (k = 0 for the first bit) goes to bit 29-k of a 30-bit frame word. word_a_o takes frame bits 29:23, word_m_o takes 22:13, band_o takes 12:11 and word_r_o takes 10:0, so every field arrives MSB first.
- R3: A bit is captured only on a falling edge of ser_clk_i while ser_en_i is high. Clock activity while ser_en_i is low changes no output.
- R4: A falling edge of ser_en_i updates the latches and pulses xfer_o high for exactly one cycle. Both appear three system clocks after the pin change, with the default two synchroniser stages.
- R5: If fewer than 30 bits were clocked in the frame, word_r_o keeps its value. The other fields are still loaded, and frame positions that were not written read as zero. The frame word is cleared when ser_en_i rises.
- R6: Falling clock edges after the 30th in a frame are ignored.
- R7: In a full frame whose R field is below 3, word_r_o keeps its value, but the A, M and band fields are still loaded.
- R8: band_o[1] is the first band bit shifted in and band_o[0] is the second.
- R9: The outputs change only in a cycle where xfer_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial bit clock, bits taken on the falling edge |
| ser_en_i | input | 1 | Frame enable, active high |
| word_a_o | output | 7 | Latched swallow count |
| word_m_o | output | 10 | Latched main count |
| word_r_o | output | 11 | Latched reference divisor |
| band_o | output | 2 | Latched band outputs |
| xfer_o | output | 1 | One-cycle transfer and resync strobe |

## Verification
The hardest cases to reach are the frame-length boundaries: a frame that stops partway through a field, one of exactly 19 bits, one of exactly 30, and one that runs past 30. In each of these the R latch must either load or hold. A further hard case is a full frame whose R value falls below the minimum. The stimulus sends frames of 10, 19, 30 and 34 bits with chosen payloads, including R values of 2 and 3. It also toggles the bit clock while the enable line is low. A behavioural model, fed through a queue of delayed pin samples, predicts every output on every clock.

// File: rtl/ser_loader_pkg.sv
package ser_loader_pkg;
  localparam int A_W    = 7;
  localparam int M_W    = 10;
  localparam int B_W    = 2;
  localparam int R_W    = 11;
  localparam int WORD_W = A_W + M_W + B_W + R_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int R_MIN  = 3;
  localparam int A_LSB  = WORD_W - A_W;
  localparam int M_LSB  = A_LSB - M_W;
  localparam int B_LSB  = M_LSB - B_W;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [M_W-1:0] m;
    logic [B_W-1:0] b;
    logic [R_W-1:0] r;
  } fields_t;
endpackage

// File: rtl/sls_pin_sync.sv
module sls_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sls_bit_capture.sv
module sls_bit_capture
  import ser_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_s,
  input  logic              sclk_s,
  input  logic              en_s,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_fall_o
);
  logic              sclk_q, en_q;
  logic [WORD_W-1:0] word_q, word_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              clk_fall, en_rise;
  logic [CNT_W-1:0]  pos;

  assign clk_fall  = sclk_q & ~sclk_s & en_s;
  assign en_rise   = ~en_q & en_s;
  assign en_fall_o = en_q & ~en_s;
  assign pos       = CNT_W'(WORD_W - 1) - cnt_q;

  always_comb begin
    word_n = word_q;
    cnt_n  = cnt_q;
    if (en_rise) begin
      word_n = '0;
      cnt_n  = '0;
    end else if (clk_fall && (cnt_q < CNT_W'(WORD_W))) begin
      word_n[pos] = data_s;
      cnt_n       = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk_s;
      en_q   <= en_s;
      word_q <= word_n;
      cnt_q  <= cnt_n;
    end
  end

  assign word_o = word_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sls_field_latch.sv
module sls_field_latch
  import ser_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output fields_t           fld_o,
  output logic              xfer_o
);
  fields_t fld_q, fld_n, fresh;
  logic    xfer_q;
  logic    r_ok;

  assign fresh = fields_t'(word_i);
  assign r_ok  = (cnt_i == CNT_W'(WORD_W)) && (fresh.r >= R_W'(R_MIN));

  always_comb begin
    fld_n = fld_q;
    if (load_i) begin
      fld_n.a = fresh.a;
      fld_n.m = fresh.m;
      fld_n.b = fresh.b;
      if (r_ok) fld_n.r = fresh.r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      xfer_q <= 1'b0;
    end else begin
      fld_q  <= fld_n;
      xfer_q <= load_i;
    end
  end

  assign fld_o  = fld_q;
  assign xfer_o = xfer_q;
endmodule

// File: rtl/ser_word_loader.sv
module ser_word_loader
  import ser_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_data_i,
  input  logic           ser_clk_i,
  input  logic           ser_en_i,
  output logic [A_W-1:0] word_a_o,
  output logic [M_W-1:0] word_m_o,
  output logic [R_W-1:0] word_r_o,
  output logic [B_W-1:0] band_o,
  output logic           xfer_o
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] cap_word;
  logic [CNT_W-1:0]  cap_cnt;
  logic              cap_load;
  fields_t           fld;

  sls_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_en_i, ser_clk_i, ser_data_i}),
    .q    (pins_s)
  );

  sls_bit_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_s   (pins_s[0]),
    .sclk_s   (pins_s[1]),
    .en_s     (pins_s[2]),
    .word_o   (cap_word),
    .cnt_o    (cap_cnt),
    .en_fall_o(cap_load)
  );

  sls_field_latch u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(cap_load),
    .word_i(cap_word),
    .cnt_i (cap_cnt),
    .fld_o (fld),
    .xfer_o(xfer_o)
  );

  assign word_a_o = fld.a;
  assign word_m_o = fld.m;
  assign word_r_o = fld.r;
  assign band_o   = fld.b;
endmodule

// File: rtl/sls_checker.sv
module sls_checker
  import ser_loader_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [A_W-1:0] a,
  input logic [M_W-1:0] m,
  input logic [R_W-1:0] r,
  input logic [B_W-1:0] b,
  input logic           xfer,
  input logic [CNT_W-1:0] cnt
);
  AST_XFER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer); // R4
  AST_CHANGE_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    ({a, m, r, b} != $past({a, m, r, b})) |-> xfer); // R9
  AST_R_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (r != $past(r)) |-> (r >= R_W'(R_MIN))); // R7
  AST_R_HOLD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (cnt != CNT_W'(WORD_W))) |-> (r == $past(r))); // R5
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W)); // R6
endmodule

bind ser_word_loader sls_checker u_chk (
  .clk (clk),
  .rst_n(rst_n),
  .a   (word_a_o),
  .m   (word_m_o),
  .r   (word_r_o),
  .b   (band_o),
  .xfer(xfer_o),
  .cnt (cap_cnt)
);

// File: tb/ser_word_loader_test.sv
module ser_word_loader_test;
  localparam int CLK_HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dat = 1'b0, sck = 1'b0, en = 1'b0;
  logic [6:0]  a_o;
  logic [9:0]  m_o;
  logic [10:0] r_o;
  logic [1:0]  b_o;
  logic        x_o;

  int checks = 0, fails = 0, xfer_seen = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  ser_word_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_data_i(dat), .ser_clk_i(sck), .ser_en_i(en),
    .word_a_o(a_o), .word_m_o(m_o), .word_r_o(r_o), .band_o(b_o), .xfer_o(x_o)
  );

  // behavioural reference: pin samples delayed through a queue
  logic [2:0]  pq[$];
  int          m_cnt;
  logic [29:0] m_word;
  logic [6:0]  e_a;
  logic [9:0]  e_m;
  logic [10:0] e_r;
  logic [1:0]  e_b;
  logic        e_x;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq = '{3'b0, 3'b0, 3'b0, 3'b0};
      m_cnt = 0; m_word = '0;
      e_a = '0; e_m = '0; e_r = '0; e_b = '0; e_x = 1'b0;
    end else begin
      logic [2:0] cur, prv;
      pq.push_back({en, sck, dat});
      if (pq.size() > 4) void'(pq.pop_front());
      cur = pq[1]; prv = pq[0];
      e_x = 1'b0;
      if (prv[2] && !cur[2]) begin
        e_x = 1'b1;
        e_a = m_word[29:23];
        e_m = m_word[22:13];
        e_b = m_word[12:11];
        if (m_cnt == 30 && m_word[10:0] >= 3) e_r = m_word[10:0];
      end
      if (!prv[2] && cur[2]) begin
        m_cnt = 0; m_word = '0;
      end else if (cur[2] && prv[1] && !cur[1] && m_cnt < 30) begin
        m_word[29 - m_cnt] = cur[0];
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({a_o, m_o, r_o, b_o, x_o} !== {e_a, e_m, e_r, e_b, e_x}) begin
        fails++;
        $display("FAIL R9 per-cycle model: actual %h expected %h",
                 {a_o, m_o, r_o, b_o, x_o}, {e_a, e_m, e_r, e_b, e_x});
      end
      if (x_o) xfer_seen++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] bits, input int n);
    en = 1'b1; step(4);
    for (int i = n - 1; i >= 0; i--) begin
      dat = bits[i]; step(3);
      sck = 1'b1; step(3);
      sck = 1'b0; step(3);
    end
    en = 1'b0; step(8);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    int xs;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 reset outputs", {a_o, m_o, r_o, b_o, x_o}, 32'h0);

    // R2 / R8: full frame
    xs = xfer_seen;
    send({34'h0, 7'h55, 10'h2C5, 2'b10, 11'd400}, 30);
    chk("R2 A field", a_o, 7'h55);
    chk("R2 M field", m_o, 10'h2C5);
    chk("R2 R field", r_o, 11'd400);
    chk("R8 band bits", b_o, 2'b10);
    chk("R4 single strobe", xfer_seen - xs, 1);

    // R5: 19-bit short frame
    send({45'h0, 7'h12, 10'h0FF, 2'b01}, 19);
    chk("R5 A short", a_o, 7'h12);
    chk("R5 M short", m_o, 10'h0FF);
    chk("R5 R held short", r_o, 11'd400);
    chk("R8 band short", b_o, 2'b01);

    // R5: 10-bit frame, unwritten positions zero
    send({54'h0, 7'h7F, 3'b101}, 10);
    chk("R5 A partial", a_o, 7'h7F);
    chk("R5 M partial", m_o, 10'h280);
    chk("R5 band partial", b_o, 2'b00);
    chk("R5 R held partial", r_o, 11'd400);

    // R7: R below minimum refused, then minimum accepted
    send({34'h0, 7'h01, 10'h008, 2'b11, 11'd2}, 30);
    chk("R7 R refused", r_o, 11'd400);
    chk("R7 A still loaded", a_o, 7'h01);
    chk("R7 band still loaded", b_o, 2'b11);
    send({34'h0, 7'h02, 10'h009, 2'b00, 11'd3}, 30);
    chk("R7 R minimum accepted", r_o, 11'd3);

    // R6: extra bits after 30th ignored
    send({30'h0, 7'h33, 10'h155, 2'b01, 11'd1234, 4'b1011}, 34);
    chk("R6 A with overrun", a_o, 7'h33);
    chk("R6 M with overrun", m_o, 10'h155);
    chk("R6 R with overrun", r_o, 11'd1234);

    // R3: clock toggles with enable low
    xs = xfer_seen;
    for (int i = 0; i < 12; i++) begin
      dat = i[0]; step(2);
      sck = 1'b1; step(2);
      sck = 1'b0; step(2);
    end
    step(5);
    chk("R3 no strobe while disabled", xfer_seen - xs, 0);
    chk("R3 outputs kept", {a_o, m_o, r_o, b_o}, {7'h33, 10'h155, 11'd1234, 2'b01});

    // R4: strobe timing, third system clock after the pin fall
    en = 1'b1; step(4);
    en = 1'b0;
    step(2);
    chk("R4 no strobe at 2 cycles", x_o, 1'b0);
    step(1);
    chk("R4 strobe at 3 cycles", x_o, 1'b1);
    step(1);
    chk("R4 strobe ends", x_o, 1'b0);
    chk("R5 empty frame zeroes A", a_o, 7'h00);
    chk("R5 empty frame keeps R", r_o, 11'd1234);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule